// File: doc/BRIEF.md
# Quadrature Edge Decoder With Direction

This block takes the A, B and Z phase signals of an incremental rotary encoder, which arrive with no relation to the system clock. It brings them into the clock domain and turns every transition of A or B into a one-cycle rotation-edge pulse. Because both edges of both phases count, one full A/B cycle gives four pulses. With each pulse the block reports the direction of the step: clockwise when A leads B by a quarter cycle, counter-clockwise when A lags B.

A two-bit mode input selects what is reported. The block can report steps in both directions, only clockwise steps, or only counter-clockwise steps. In the single-direction modes a step is found by comparing the present A/B levels with a snapshot of A, B and Z. The snapshot is taken at the last reported edge and is always visible on an output. A divided timing output toggles once for every N reported edges, with N set from an input. A sticky flag marks any cycle in which A and B changed together, which a real encoder cannot produce.

A position counter sits downstream and consumes the pulse and direction. All control arrives on plain input ports.

Top module: `quad_edge_decoder`

## Requirements
- R1: A single change of A or B appears on `edge_pulse` as a pulse one cycle wide. The pulse rises at the third rising clock edge after the change: two synchronizer stages, then the output register.
- R2: With `det_mode` at 00, every single change of A or B yields exactly one pulse. A full A/B cycle therefore yields four pulses.
- R3: The step order AB = 00, 10, 11, 01, 00 is clockwise and the reverse order is counter-clockwise. On each pulse `dir_cw` becomes 1 for a clockwise step and 0 for a counter-clockwise step. Between pulses it holds its value.
- R4: With `det_mode` at 01, the synchronized A/B levels are compared with the A/B bits of the snapshot. An edge is reported only when they differ in exactly one bit and the step from snapshot to present levels is clockwise. A blocked step changes no output.
- R5: With `det_mode` at 10, the same comparison applies, but only counter-clockwise steps are reported.
- R6: A `det_mode` value of 11 behaves exactly as 00.
- R7: `snap_mon` holds {A, B, Z} as synchronized in the cycle of the last reported edge. A change of Z alone produces no pulse and leaves `snap_mon` unchanged.
- R8: `div_out` toggles together with every N-th pulse, where N = `div_sel` + 1 (1 to 16). Counting starts from reset.
- R9: If the synchronized A and B both change in the same cycle, no pulse is produced and `seq_err` goes to 1. It stays at 1 until reset.
- R10: While reset is low and just after it, `edge_pulse`, `dir_cw`, `snap_mon`, `div_out` and `seq_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_z | input | 1 | Encoder index phase, asynchronous |
| det_mode | input | 2 | 00/11 both directions, 01 clockwise only, 10 counter-clockwise only |
| div_sel | input | DIV_W | Divide factor minus one |
| edge_pulse | output | 1 | One-cycle rotation-edge pulse |
| dir_cw | output | 1 | Direction of last reported edge, 1 = clockwise |
| snap_mon | output | 3 | {A, B, Z} captured at last reported edge |
| div_out | output | 1 | Divided edge pulse |
| seq_err | output | 1 | Sticky flag for a simultaneous A/B change |

## Verification
The assertions guard several rules on every cycle. The direction flag, the snapshot and the divided output may only move in a cycle that carries a pulse. The error flag never clears. A single-direction mode never lets through a step against its direction. Whether pulses appear at all, whether they come at the exact latency, and the four-per-cycle count need the bench's scenarios. The same holds for the divide-by-N spacing and for the behaviour of the snapshot during reversals. For these, the bench steps the inputs through forward runs, backward runs and short back-and-forth jitter in every mode and under several divide factors. It compares each result against a model written from the requirements.

// File: rtl/quad_edge_decoder.sv
module quad_edge_decoder #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic [1:0]       det_mode,
  input  logic [DIV_W-1:0] div_sel,
  output logic             edge_pulse,
  output logic             dir_cw,
  output logic [2:0]       snap_mon,
  output logic             div_out,
  output logic             seq_err
);

  logic [2:0]       sync1, sync2;
  logic [1:0]       prev_ab, cur_ab, ref_ab;
  logic [DIV_W-1:0] div_cnt;
  logic             one_dir, one_step, illegal, step_cw, allow, hit;

  assign cur_ab   = sync2[2:1];
  assign one_dir  = det_mode[1] ^ det_mode[0];
  assign ref_ab   = one_dir ? snap_mon[2:1] : prev_ab;
  assign one_step = ^(cur_ab ^ ref_ab);
  assign illegal  = &(cur_ab ^ prev_ab);
  assign step_cw  = (ref_ab[1] == cur_ab[0]);
  assign allow    = (det_mode == 2'b01) ? step_cw :
                    (det_mode == 2'b10) ? !step_cw : 1'b1;
  assign hit      = one_step && !illegal && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev_ab <= '0;
    end else begin
      sync1   <= {enc_a, enc_b, enc_z};
      sync2   <= sync1;
      prev_ab <= cur_ab;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_pulse <= 1'b0;
      dir_cw     <= 1'b0;
      snap_mon   <= '0;
      seq_err    <= 1'b0;
    end else begin
      edge_pulse <= hit;
      seq_err    <= seq_err | illegal;
      if (hit) begin
        dir_cw   <= step_cw;
        snap_mon <= sync2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      div_out <= 1'b0;
    end else if (hit) begin
      if (div_cnt >= div_sel) begin
        div_cnt <= '0;
        div_out <= ~div_out;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  p_dir_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_pulse |-> $stable(dir_cw));

  p_snap_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_pulse |-> $stable(snap_mon));

  p_div_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_out) |-> edge_pulse);

  p_cw_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && $past(det_mode) == 2'b01) |-> dir_cw);

  p_ccw_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && $past(det_mode) == 2'b10) |-> !dir_cw);

endmodule

// File: tb/quad_edge_decoder_tb.sv
module quad_edge_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic [1:0] det_mode = 2'b00;
  logic [3:0] div_sel = 4'd0;
  logic       edge_pulse, dir_cw, div_out, seq_err;
  logic [2:0] snap_mon;

  int checks = 0, errors = 0;
  logic [1:0] m_prev, m_snap_ab;
  logic [2:0] m_snap;
  logic       m_dir, m_div, m_err;
  int         m_cnt;

  quad_edge_decoder #(.DIV_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .det_mode(det_mode), .div_sel(div_sel), .edge_pulse(edge_pulse),
    .dir_cw(dir_cw), .snap_mon(snap_mon), .div_out(div_out), .seq_err(seq_err)
  );

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] nxt(input logic [1:0] ab, input bit cw);
    case (ab)
      2'b00: return cw ? 2'b10 : 2'b01;
      2'b10: return cw ? 2'b11 : 2'b00;
      2'b11: return cw ? 2'b01 : 2'b10;
      default: return cw ? 2'b00 : 2'b11;
    endcase
  endfunction

  task automatic do_reset(input logic [1:0] mode, input logic [3:0] dv);
    @(negedge clk);
    rst_n = 1'b0; enc_a = 0; enc_b = 0; enc_z = 0;
    det_mode = mode; div_sel = dv;
    repeat (3) @(negedge clk);
    chk(edge_pulse == 0 && dir_cw == 0 && snap_mon == 0 && div_out == 0 && seq_err == 0,
        "R10 reset state", {edge_pulse, dir_cw, snap_mon, div_out, seq_err}, 0);
    rst_n = 1'b1;
    m_prev = 0; m_snap = 0; m_dir = 0; m_div = 0; m_err = 0; m_cnt = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic step(input logic [1:0] nab, input logic nz);
    bit one_dir, ill, one, cw, allow, expp;
    logic [1:0] rf;
    int seen = 0, pos = 0;
    one_dir = det_mode == 2'b01 || det_mode == 2'b10;
    rf = one_dir ? m_snap[2:1] : m_prev;
    ill = (nab ^ m_prev) == 2'b11;
    one = (nab ^ rf) == 2'b01 || (nab ^ rf) == 2'b10;
    cw = nxt(rf, 1'b1) == nab;
    allow = det_mode == 2'b01 ? cw : det_mode == 2'b10 ? !cw : 1'b1;
    expp = one && !ill && allow;
    enc_a = nab[1]; enc_b = nab[0]; enc_z = nz;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (edge_pulse) begin seen++; pos = k; end
    end
    m_prev = nab;
    m_err = m_err | ill;
    if (expp) begin
      m_dir = cw; m_snap = {nab, nz};
      if (m_cnt >= int'(div_sel)) begin m_cnt = 0; m_div = ~m_div; end
      else m_cnt++;
    end
    chk(seen == int'(expp), "R2 R4 R5 R6 pulse count", seen, int'(expp));
    if (expp) chk(pos == 3, "R1 pulse latency", pos, 3);
    chk(dir_cw == m_dir, "R3 direction", dir_cw, m_dir);
    chk(snap_mon == m_snap, "R7 snapshot", snap_mon, m_snap);
    chk(div_out == m_div, "R8 divided output", div_out, m_div);
    chk(seq_err == m_err, "R9 error flag", seq_err, m_err);
  endtask

  initial begin
    logic [1:0] ab;
    logic [3:0] dvs [5] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd15};
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 5; d++) begin
        do_reset(2'(m), dvs[d]);
        ab = 2'b00;
        for (int i = 0; i < 9; i++) begin ab = nxt(ab, 1'b1); step(ab, 1'(i % 5 == 0)); end
        for (int r = 0; r < 2; r++) begin
          ab = nxt(ab, 1'b0); step(ab, 1'b0);
          ab = nxt(ab, 1'b0); step(ab, 1'b0);
          ab = nxt(ab, 1'b1); step(ab, 1'b1);
          ab = nxt(ab, 1'b1); step(ab, 1'b0);
        end
        step(ab, 1'b1);
        step(ab, 1'b0);
        for (int i = 0; i < 11; i++) begin ab = nxt(ab, 1'b0); step(ab, 1'(i % 4 == 1)); end
        for (int r = 0; r < 2; r++) begin
          ab = nxt(ab, 1'b1); step(ab, 1'b0);
          ab = nxt(ab, 1'b1); step(ab, 1'b0);
          ab = nxt(ab, 1'b0); step(ab, 1'b0);
          ab = nxt(ab, 1'b0); step(ab, 1'b0);
        end
        ab = ~ab; step(ab, 1'b0);
        for (int i = 0; i < 5; i++) begin ab = nxt(ab, 1'b1); step(ab, 1'b0); end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule